// File: doc/BRIEF.md
# Packed Tag Memory Access Engine

This block carries out allocation-tag reads and writes against a byte-wide tag RAM. Every 16-byte granule of data memory owns a 4-bit tag, and two neighbouring granules share one RAM byte. A requester presents one command at a time: an opcode, a byte address, a 64-bit operand and an `untagged` qualifier. The engine turns that command into a short sequence of RAM accesses and answers with one response beat. The beat carries either the loaded value or an alignment fault.

The operations are as follows. A single tag can be read or written. A pair of adjacent granules can be written with one tag. Sixteen tags can be moved as one little-endian 64-bit word, in either direction. One tag can be written across a whole zeroing block, whose size is set by a parameter. Single tags sit inside shared bytes, so they are updated by read-modify-write. A pair that starts on an odd granule straddles two bytes and costs two read-modify-write passes. A pair that starts on an even granule costs one plain byte write.

Address translation, permission checks and zeroing of the data itself are handled outside this block. The `untagged` input marks a region that has no tag storage, and for such a region the engine makes no RAM access at all.

Top module: `tagx_engine`

## Requirements
- R1: After reset, `cmd_ready` is 1, and `rsp_valid` and `ram_en` are both 0.
- R2: The tag RAM byte index is `cmd_addr >> 5`, truncated to `RAM_AW` bits. Address bit 4 picks the nibble within that byte: 0 selects bits [3:0] and 1 selects bits [7:4].
- R3: An opcode 1 (single store) or opcode 2 (pair store) whose address has a nonzero value in bits [3:0] receives a response one cycle after acceptance, with `rsp_fault`=1 and `rsp_data`=0. It makes no RAM access, and this holds whether or not `untagged` is set.
- R4: Opcode 1 (single store) writes `cmd_data[59:56]` into the selected nibble only, by read-modify-write. The other nibble of the byte keeps its old value.
- R5: Opcode 2 (pair store) with address bit 4 equal to 0 performs exactly one RAM write, of the byte {tag, tag}.
- R6: Opcode 2 (pair store) with address bit 4 equal to 1 writes the tag into bits [7:4] of byte `idx` and into bits [3:0] of byte `idx+1`. Both other nibbles are kept.
- R7: Opcode 0 (single load) returns `cmd_data` with bits [59:56] replaced by the selected nibble. When `untagged` is set, those bits are 0 instead.
- R8: Opcode 3 (bulk load) clears bits [7:0] of the address, giving the base byte `(addr>>8)<<3`. It returns tag byte `base+k` in `rsp_data[8k+7:8k]` for k = 0..7. When `untagged` is set, it returns 0.
- R9: Opcode 4 (bulk store) writes `cmd_data[8k+7:8k]` into tag byte `base+k` for k = 0..7, using the same base as R8. When `untagged` is set, no byte is written.
- R10: Opcode 5 (block fill) clears the low `ZBLK_LOG2` address bits, where `ZBLK_LOG2` ranges from 6 to 11. It then writes the byte {t, t}, with t = `cmd_data[3:0]`, into all `2^(ZBLK_LOG2-5)` tag bytes of the block. When `untagged` is set, nothing is written.
- R11: A command with `untagged` set makes no RAM access, and its response arrives one cycle after acceptance.
- R12: The engine makes at most one RAM access per cycle. `cmd_ready` stays 0 from acceptance until the cycle after the last RAM access has been performed. `rsp_valid` pulses for one cycle, and that cycle is the one in which `cmd_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is presented |
| cmd_ready | output | 1 | The engine is idle and accepts a command |
| cmd_op | input | 3 | Operation: 0 single load, 1 single store, 2 pair store, 3 bulk load, 4 bulk store, 5 fill |
| cmd_addr | input | ADDR_W | Byte address of the access |
| cmd_data | input | DATA_W | Pointer, tag source or bulk data |
| cmd_untagged | input | 1 | The region has no tag storage |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Alignment fault |
| rsp_data | output | DATA_W | Loaded pointer or bulk word |
| ram_en | output | 1 | Tag RAM access enable |
| ram_we | output | 1 | Tag RAM write when 1, read when 0 |
| ram_addr | output | RAM_AW | Tag RAM byte index |
| ram_wdata | output | 8 | Tag RAM write byte |
| ram_rdata | input | 8 | Tag RAM read byte, valid the cycle after a read is performed |

## Verification
The assertions assume that the tag RAM returns the addressed byte one cycle after a read, and that the requester holds `cmd_op`, `cmd_addr`, `cmd_data` and `cmd_untagged` steady while `cmd_valid` is high. They also assume that `cmd_valid` is only raised for one command at a time. The stimulus presents each command for exactly one cycle, while the engine is idle. It does not present the next command until the previous response has been seen. A bench-side RAM model with the stated read latency answers every access.

// File: rtl/tagx_pkg.sv
package tagx_pkg;

    typedef enum logic [2:0] {
        OP_LD1  = 3'd0,
        OP_ST1  = 3'd1,
        OP_ST2  = 3'd2,
        OP_LDM  = 3'd3,
        OP_STM  = 3'd4,
        OP_FILL = 3'd5
    } tagx_op_e;

    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_RMW_WAIT  = 3'd1,
        S_RMW_MERGE = 3'd2,
        S_RMW_NEXT  = 3'd3,
        S_BLK_RD    = 3'd4,
        S_BLK_WR    = 3'd5,
        S_WR_DONE   = 3'd6
    } tagx_state_e;

endpackage

// File: rtl/tagx_addr_map.sv
// Splits a byte address into a tag RAM index, a nibble select, an
// alignment flag and the aligned bases used by the bulk and fill operations.
module tagx_addr_map #(
    parameter int ADDR_W    = 13,
    parameter int RAM_AW    = 8,
    parameter int GRAN_LOG2 = 4,
    parameter int BULK_LOG2 = 3,
    parameter int FILL_LOG2 = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [RAM_AW-1:0] byte_idx,
    output logic              upper,
    output logic              misaligned,
    output logic [RAM_AW-1:0] bulk_base,
    output logic [RAM_AW-1:0] fill_base
);
    localparam int PAIR_LOG2 = GRAN_LOG2 + 1;
    localparam logic [RAM_AW-1:0] BULK_MASK = ~RAM_AW'((1 << BULK_LOG2) - 1);
    localparam logic [RAM_AW-1:0] FILL_MASK = ~RAM_AW'((1 << FILL_LOG2) - 1);

    assign byte_idx   = addr[PAIR_LOG2 +: RAM_AW];
    assign upper      = addr[GRAN_LOG2];
    assign misaligned = |addr[GRAN_LOG2-1:0];
    assign bulk_base  = byte_idx & BULK_MASK;
    assign fill_base  = byte_idx & FILL_MASK;
endmodule

// File: rtl/tagx_nib_merge.sv
// Replaces the enabled nibble lanes of a tag byte with a new tag.
module tagx_nib_merge #(
    parameter int TAG_W = 4
) (
    input  logic [2*TAG_W-1:0] old_byte,
    input  logic [TAG_W-1:0]   tag,
    input  logic [1:0]         lane_we,
    output logic [2*TAG_W-1:0] merged
);
    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign merged[g*TAG_W +: TAG_W] = lane_we[g] ? tag : old_byte[g*TAG_W +: TAG_W];
    end
endmodule

// File: rtl/tagx_engine.sv
module tagx_engine
    import tagx_pkg::*;
#(
    parameter int RAM_AW    = 8,
    parameter int GRAN_LOG2 = 4,
    parameter int ADDR_W    = RAM_AW + GRAN_LOG2 + 1,
    parameter int DATA_W    = 64,
    parameter int TAG_LSB   = 56,
    parameter int ZBLK_LOG2 = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              cmd_untagged,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [DATA_W-1:0] rsp_data,
    output logic              ram_en,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [7:0]        ram_wdata,
    input  logic [7:0]        ram_rdata
);
    localparam int TAG_W      = 4;
    localparam int PAIR_LOG2  = GRAN_LOG2 + 1;
    localparam int BULK_BYTES = DATA_W / 8;
    localparam int BULK_LOG2  = $clog2(BULK_BYTES);
    localparam int FILL_LOG2  = ZBLK_LOG2 - PAIR_LOG2;
    localparam int FILL_BYTES = 1 << FILL_LOG2;
    localparam int MAX_BYTES  = (BULK_BYTES > FILL_BYTES) ? BULK_BYTES : FILL_BYTES;
    localparam int CNT_W      = $clog2(MAX_BYTES) + 1;

    typedef struct packed {
        tagx_state_e       state;
        tagx_op_e          op;
        logic              hi;
        logic              second;
        logic              got;
        logic [RAM_AW-1:0] idx;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
        logic [CNT_W-1:0]  iss;
        logic [CNT_W-1:0]  cap;
        logic [CNT_W-1:0]  last;
        logic              ram_en;
        logic              ram_we;
        logic [RAM_AW-1:0] ram_addr;
        logic [7:0]        ram_wdata;
        logic              rsp_valid;
        logic              rsp_fault;
        logic [DATA_W-1:0] rsp_data;
    } regs_t;

    regs_t r_d, r_q;

    logic [RAM_AW-1:0] m_idx, m_bulk, m_fill;
    logic              m_upper, m_mis;
    logic [7:0]        merged;
    tagx_op_e          op_in;

    assign op_in = tagx_op_e'(cmd_op);

    tagx_addr_map #(
        .ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .GRAN_LOG2(GRAN_LOG2),
        .BULK_LOG2(BULK_LOG2), .FILL_LOG2(FILL_LOG2)
    ) u_map (
        .addr(cmd_addr), .byte_idx(m_idx), .upper(m_upper),
        .misaligned(m_mis), .bulk_base(m_bulk), .fill_base(m_fill)
    );

    tagx_nib_merge #(.TAG_W(TAG_W)) u_merge (
        .old_byte(ram_rdata), .tag(r_q.tag),
        .lane_we(r_q.hi ? 2'b10 : 2'b01), .merged(merged)
    );

    always_comb begin
        logic [DATA_W-1:0] ld_word;
        logic [DATA_W-1:0] cmd_word;
        logic [DATA_W-1:0] shifted;
        logic [TAG_W-1:0]  cmd_tag;
        logic [TAG_W-1:0]  fill_tag;

        r_d           = r_q;
        r_d.ram_en    = 1'b0;
        r_d.ram_we    = 1'b0;
        r_d.rsp_valid = 1'b0;
        r_d.rsp_fault = 1'b0;
        r_d.got       = r_q.ram_en && !r_q.ram_we;

        ld_word  = r_q.data;
        ld_word[TAG_LSB +: TAG_W] = r_q.hi ? ram_rdata[7:4] : ram_rdata[3:0];
        cmd_word = cmd_data;
        cmd_word[TAG_LSB +: TAG_W] = '0;
        shifted  = {ram_rdata, r_q.data[DATA_W-1:8]};
        cmd_tag  = cmd_data[TAG_LSB +: TAG_W];
        fill_tag = cmd_data[TAG_W-1:0];

        case (r_q.state)
            S_IDLE: if (cmd_valid) begin
                r_d.op       = op_in;
                r_d.idx      = m_idx;
                r_d.hi       = m_upper;
                r_d.second   = 1'b0;
                r_d.data     = cmd_data;
                r_d.tag      = cmd_tag;
                r_d.iss      = CNT_W'(1);
                r_d.cap      = '0;
                r_d.last     = CNT_W'(BULK_BYTES - 1);
                r_d.rsp_data = '0;
                r_d.ram_addr = m_idx;
                case (op_in)
                    OP_LD1: begin
                        if (cmd_untagged) begin
                            r_d.rsp_valid = 1'b1;
                            r_d.rsp_data  = cmd_word;
                        end else begin
                            r_d.ram_en = 1'b1;
                            r_d.state  = S_RMW_WAIT;
                        end
                    end
                    OP_ST1, OP_ST2: begin
                        if (m_mis || cmd_untagged) begin
                            r_d.rsp_valid = 1'b1;
                            r_d.rsp_fault = m_mis;
                        end else if (op_in == OP_ST2 && !m_upper) begin
                            r_d.ram_en    = 1'b1;
                            r_d.ram_we    = 1'b1;
                            r_d.ram_wdata = {cmd_tag, cmd_tag};
                            r_d.state     = S_WR_DONE;
                        end else begin
                            r_d.ram_en = 1'b1;
                            r_d.second = (op_in == OP_ST2);
                            r_d.state  = S_RMW_WAIT;
                        end
                    end
                    OP_LDM: begin
                        if (cmd_untagged) begin
                            r_d.rsp_valid = 1'b1;
                        end else begin
                            r_d.ram_en   = 1'b1;
                            r_d.ram_addr = m_bulk;
                            r_d.idx      = m_bulk;
                            r_d.data     = '0;
                            r_d.state    = S_BLK_RD;
                        end
                    end
                    OP_STM, OP_FILL: begin
                        if (cmd_untagged) begin
                            r_d.rsp_valid = 1'b1;
                        end else begin
                            r_d.ram_en = 1'b1;
                            r_d.ram_we = 1'b1;
                            r_d.state  = S_BLK_WR;
                            if (op_in == OP_FILL) begin
                                r_d.ram_addr  = m_fill;
                                r_d.idx       = m_fill;
                                r_d.tag       = fill_tag;
                                r_d.ram_wdata = {fill_tag, fill_tag};
                                r_d.last      = CNT_W'(FILL_BYTES - 1);
                            end else begin
                                r_d.ram_addr  = m_bulk;
                                r_d.idx       = m_bulk;
                                r_d.ram_wdata = cmd_data[7:0];
                                r_d.data      = cmd_data >> 8;
                            end
                        end
                    end
                    default: r_d.rsp_valid = 1'b1;
                endcase
            end
            S_RMW_WAIT: r_d.state = S_RMW_MERGE;
            S_RMW_MERGE: begin
                if (r_q.op == OP_LD1) begin
                    r_d.state     = S_IDLE;
                    r_d.rsp_valid = 1'b1;
                    r_d.rsp_data  = ld_word;
                end else begin
                    r_d.ram_en    = 1'b1;
                    r_d.ram_we    = 1'b1;
                    r_d.ram_addr  = r_q.idx;
                    r_d.ram_wdata = merged;
                    r_d.state     = r_q.second ? S_RMW_NEXT : S_WR_DONE;
                end
            end
            S_RMW_NEXT: begin
                r_d.idx      = r_q.idx + 1'b1;
                r_d.hi       = 1'b0;
                r_d.second   = 1'b0;
                r_d.ram_en   = 1'b1;
                r_d.ram_addr = r_q.idx + 1'b1;
                r_d.state    = S_RMW_WAIT;
            end
            S_BLK_RD: begin
                if (r_q.iss <= r_q.last) begin
                    r_d.ram_en   = 1'b1;
                    r_d.ram_addr = r_q.idx + RAM_AW'(r_q.iss);
                    r_d.iss      = r_q.iss + 1'b1;
                end
                if (r_q.got) begin
                    r_d.data = shifted;
                    r_d.cap  = r_q.cap + 1'b1;
                    if (r_q.cap == r_q.last) begin
                        r_d.state     = S_IDLE;
                        r_d.rsp_valid = 1'b1;
                        r_d.rsp_data  = shifted;
                    end
                end
            end
            S_BLK_WR: begin
                r_d.ram_en    = 1'b1;
                r_d.ram_we    = 1'b1;
                r_d.ram_addr  = r_q.idx + RAM_AW'(r_q.iss);
                r_d.ram_wdata = (r_q.op == OP_FILL) ? {r_q.tag, r_q.tag} : r_q.data[7:0];
                r_d.data      = r_q.data >> 8;
                if (r_q.iss == r_q.last) r_d.state = S_WR_DONE;
                else                     r_d.iss   = r_q.iss + 1'b1;
            end
            S_WR_DONE: begin
                r_d.state     = S_IDLE;
                r_d.rsp_valid = 1'b1;
                r_d.rsp_data  = '0;
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cmd_ready = (r_q.state == S_IDLE);
    assign rsp_valid = r_q.rsp_valid;
    assign rsp_fault = r_q.rsp_fault;
    assign rsp_data  = r_q.rsp_data;
    assign ram_en    = r_q.ram_en;
    assign ram_we    = r_q.ram_we;
    assign ram_addr  = r_q.ram_addr;
    assign ram_wdata = r_q.ram_wdata;

    // A misaligned single or pair store faults at once and never touches the RAM.
    assert_fault_no_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && m_mis && (op_in == OP_ST1 || op_in == OP_ST2))
        |=> (!ram_en && rsp_valid && rsp_fault));

    assert_fault_has_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_valid);

    // Untagged commands answer in one cycle with no RAM traffic.
    assert_untagged_no_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_untagged) |=> (!ram_en && rsp_valid));

    // The engine stays busy while any RAM access is outstanding.
    assert_busy_during_access_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> !cmd_ready);

    assert_rsp_when_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> cmd_ready);

    // An even pair store issues its write straight from idle, replicated.
    assert_pair_replicated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && ram_we && r_q.op == OP_ST2 && $past(r_q.state) == S_IDLE)
        |-> (ram_wdata[7:4] == ram_wdata[3:0]));

    assert_fill_replicated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && ram_we && r_q.op == OP_FILL) |-> (ram_wdata[7:4] == ram_wdata[3:0]));

endmodule

// File: tb/tb_tagx_engine.sv
module tb_tagx_engine;
    localparam int RAM_AW    = 8;
    localparam int ZBLK_LOG2 = 8;
    localparam int ADDR_W    = 13;
    localparam int RAM_N     = 1 << RAM_AW;

    localparam logic [2:0] OPC_LD1  = 3'd0;
    localparam logic [2:0] OPC_ST1  = 3'd1;
    localparam logic [2:0] OPC_ST2  = 3'd2;
    localparam logic [2:0] OPC_LDM  = 3'd3;
    localparam logic [2:0] OPC_STM  = 3'd4;
    localparam logic [2:0] OPC_FILL = 3'd5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [2:0]        cmd_op = '0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [63:0]       cmd_data = '0;
    logic              cmd_untagged = 1'b0;
    logic              rsp_valid, rsp_fault;
    logic [63:0]       rsp_data;
    logic              ram_en, ram_we;
    logic [RAM_AW-1:0] ram_addr;
    logic [7:0]        ram_wdata;
    logic [7:0]        ram_rdata = '0;

    logic [7:0] ram     [RAM_N];
    logic [7:0] ref_mem [RAM_N];

    int checks = 0;
    int fails  = 0;
    int acc_cnt = 0;
    int rsp_cnt = 0;

    logic [64:0] exp_q [$];
    string       req_q [$];

    always #10 clk = ~clk;

    tagx_engine #(.RAM_AW(RAM_AW), .ZBLK_LOG2(ZBLK_LOG2)) dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_untagged(cmd_untagged),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_data(rsp_data),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // Tag RAM model: one access per edge, read data one cycle later.
    always @(posedge clk) begin
        if (ram_en) begin
            acc_cnt = acc_cnt + 1;
            if (ram_we) ram[ram_addr] = ram_wdata;
            else        ram_rdata    <= ram[ram_addr];
        end
    end

    task automatic check(input bit ok, input string req, input logic [64:0] act, input logic [64:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: compare each response against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R12 unexpected response", {rsp_fault, rsp_data}, '0);
            end else begin
                logic [64:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check({rsp_fault, rsp_data} === e, r, {rsp_fault, rsp_data}, e);
            end
            rsp_cnt++;
        end
    end

    task automatic run_op(input logic [2:0] op, input logic [ADDR_W-1:0] addr,
                          input logic [63:0] data, input logic untg,
                          input int exp_acc, input string req);
        int idx, base, n, prev, wd, bad;
        logic hi, mis;
        logic [3:0] t;
        logic [63:0] d;
        logic [64:0] e;
        idx = int'(addr[ADDR_W-1:5]);
        hi  = addr[4];
        mis = |addr[3:0];
        t   = data[59:56];
        e   = '0;
        case (op)
            OPC_LD1: begin
                d = data;
                d[59:56] = untg ? 4'h0 : (hi ? ref_mem[idx][7:4] : ref_mem[idx][3:0]);
                e = {1'b0, d};
            end
            OPC_ST1: begin
                if (mis) e = {1'b1, 64'h0};
                else if (!untg) begin
                    if (hi) ref_mem[idx][7:4] = t;
                    else    ref_mem[idx][3:0] = t;
                end
            end
            OPC_ST2: begin
                if (mis) e = {1'b1, 64'h0};
                else if (!untg) begin
                    if (!hi) ref_mem[idx] = {t, t};
                    else begin
                        ref_mem[idx][7:4] = t;
                        ref_mem[(idx + 1) % RAM_N][3:0] = t;
                    end
                end
            end
            OPC_LDM: begin
                base = idx & ~7;
                if (!untg)
                    for (int k = 0; k < 8; k++) e[8*k +: 8] = ref_mem[base + k];
            end
            OPC_STM: begin
                base = idx & ~7;
                if (!untg)
                    for (int k = 0; k < 8; k++) ref_mem[base + k] = data[8*k +: 8];
            end
            OPC_FILL: begin
                n = 1 << (ZBLK_LOG2 - 5);
                base = idx & ~(n - 1);
                if (!untg)
                    for (int k = 0; k < n; k++) ref_mem[base + k] = {data[3:0], data[3:0]};
            end
            default: e = '0;
        endcase
        exp_q.push_back(e);
        req_q.push_back(req);

        @(negedge clk);
        cmd_valid    = 1'b1;
        cmd_op       = op;
        cmd_addr     = addr;
        cmd_data     = data;
        cmd_untagged = untg;
        acc_cnt      = 0;
        prev         = rsp_cnt;
        @(negedge clk);
        cmd_valid = 1'b0;
        wd = 0;
        while (rsp_cnt == prev && wd < 1000) begin
            @(negedge clk);
            wd++;
        end
        check(rsp_cnt != prev, {req, " response timeout"}, 65'(rsp_cnt), 65'(prev + 1));
        bad = 0;
        for (int i = 0; i < RAM_N; i++) if (ram[i] !== ref_mem[i]) bad++;
        check(bad == 0, {req, " tag memory contents"}, 65'(bad), 65'(0));
        check(acc_cnt == exp_acc, {req, " RAM access count"}, 65'(acc_cnt), 65'(exp_acc));
    endtask

    initial begin
        for (int i = 0; i < RAM_N; i++) begin
            ram[i]     = 8'((i * 37 + 5) % 256);
            ref_mem[i] = 8'((i * 37 + 5) % 256);
        end
        repeat (3) @(negedge clk);
        check(cmd_ready === 1'b1, "R1 reset ready", 65'(cmd_ready), 65'(1));
        check(rsp_valid === 1'b0, "R1 reset rsp_valid", 65'(rsp_valid), 65'(0));
        check(ram_en === 1'b0, "R1 reset ram_en", 65'(ram_en), 65'(0));
        rst_n = 1'b1;
        @(negedge clk);

        run_op(OPC_LD1, 13'h040, 64'hFEDC_BA98_7654_3210, 1'b0, 1, "R2 R7 load lower nibble");
        run_op(OPC_LD1, 13'h050, 64'hFEDC_BA98_7654_3210, 1'b0, 1, "R2 R7 load upper nibble");
        run_op(OPC_ST1, 13'h130, 64'h0C00_0000_0000_0000, 1'b0, 2, "R4 store upper nibble");
        run_op(OPC_ST1, 13'h120, 64'h0700_0000_0000_0000, 1'b0, 2, "R4 store lower nibble");
        run_op(OPC_LD1, 13'h130, 64'h0000_0000_0000_0000, 1'b0, 1, "R4 reload stored tag");
        run_op(OPC_ST1, 13'h134, 64'h0500_0000_0000_0000, 1'b0, 0, "R3 single store misaligned");
        run_op(OPC_ST2, 13'h200, 64'h0500_0000_0000_0000, 1'b0, 1, "R5 even pair store");
        run_op(OPC_ST2, 13'h230, 64'h0A00_0000_0000_0000, 1'b0, 4, "R6 odd pair store");
        run_op(OPC_ST2, 13'h208, 64'h0300_0000_0000_0000, 1'b1, 0, "R3 pair misaligned untagged");
        run_op(OPC_LD1, 13'h040, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 0, "R7 R11 untagged load");
        run_op(OPC_ST1, 13'h140, 64'h0900_0000_0000_0000, 1'b1, 0, "R11 untagged single store");
        run_op(OPC_STM, 13'h345, 64'h0123_4567_89AB_CDEF, 1'b0, 8, "R9 bulk store");
        run_op(OPC_LDM, 13'h3FF, 64'h0, 1'b0, 8, "R8 bulk load after store");
        run_op(OPC_LDM, 13'h500, 64'h0, 1'b0, 8, "R8 bulk load pattern");
        run_op(OPC_LDM, 13'h500, 64'h0, 1'b1, 0, "R8 R11 untagged bulk load");
        run_op(OPC_STM, 13'h600, 64'h1111_2222_3333_4444, 1'b1, 0, "R9 untagged bulk store");
        run_op(OPC_FILL, 13'h777, 64'h0000_0000_0000_0003, 1'b0, 8, "R10 block fill");
        run_op(OPC_LDM, 13'h700, 64'h0, 1'b0, 8, "R10 R12 read back fill");
        run_op(OPC_FILL, 13'h800, 64'h0000_0000_0000_000E, 1'b1, 0, "R10 untagged fill");

        check(exp_q.size() == 0, "R12 responses outstanding", 65'(exp_q.size()), 65'(0));
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule